// File: doc/BRIEF.md
# Trace Buffer Fill Level and Watermark Monitor

This block tracks how many 32-bit words sit in a trace FIFO buffer. Whoever owns the buffer sends one strobe per word written and one per word read. The block keeps the current occupancy and records the highest occupancy reached since software last sampled it. It also raises a full indication when the free space drops to a programmed vacancy threshold or below.

Sampling the peak register is destructive. The read returns the peak and reloads the register with the occupancy at that moment, so each read covers the interval since the previous read.

The vacancy comparison applies only when the buffer runs as a software-drained or hardware-drained FIFO. A rising edge on capture-enable starts a new session: it clears the level and the peak, and the block reports that edge on a one-cycle output. The buffer memory, its pointers and the register decode are not part of this block.

Top module: `trace_fill_mon`

## Requirements
- R1: After reset the peak output is 0, the full output is 0 and the watermark is 0; the level output reads 0 because capture is off.
- R2: While capture is enabled, the level changes at the clock edge after the strobes are sampled. A write strobe alone adds 1, a read strobe alone subtracts 1, and both together leave the level unchanged.
- R3: The level is $clog2(DEPTH)+1 bits wide. It stops at DEPTH when writes continue and stops at 0 when reads continue.
- R4: While capture is enabled, the peak register follows the highest level seen, one cycle behind the level.
- R5: A peak read strobe with the lock input low loads the peak register with the current level at that clock edge.
- R6: While the lock input is high, the peak output reads 0, and a peak read strobe leaves the peak register unchanged.
- R7: While capture is disabled, the level output reads 0 and the peak register keeps its value.
- R8: In the cycle where capture-enable is 1 and was 0 in the previous cycle, the edge-clear output is 1 for exactly that cycle. At that edge the level and the peak go to 0, and word strobes sampled in that cycle are ignored.
- R9: In mode 1 (software FIFO) or mode 2 (hardware FIFO) with capture enabled, full goes to 1 one cycle after the level becomes at least DEPTH minus the watermark. It goes back to 0 one cycle after the level falls below that threshold.
- R10: In mode 0 (circular) and mode 3, full stays at 0 whatever the level.
- R11: With the watermark at DEPTH-1, the largest legal value, full rises after the first word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| captEn | input | 1 | Capture enable |
| bufMode | input | 2 | 0 circular, 1 software FIFO, 2 hardware FIFO, 3 treated as circular |
| wordWr | input | 1 | One 32-bit word was written to the buffer |
| wordRd | input | 1 | One 32-bit word was read from the buffer |
| wmWrEn | input | 1 | Load the vacancy watermark |
| wmWrData | input | $clog2(DEPTH) | New watermark value, in words |
| peakRdEn | input | 1 | Software read of the peak register |
| locked | input | 1 | Register access is locked |
| curLevel | output | $clog2(DEPTH)+1 | Current fill level, 0 while capture is off |
| peakLevel | output | $clog2(DEPTH)+1 | Peak read value, 0 while locked |
| fullOut | output | 1 | Registered watermark-full flag |
| enClr | output | 1 | Capture-enable rising-edge clear pulse |

## Verification
The level counter is driven with bursts of writes only, reads only, and simultaneous write/read pairs. These separate increment, decrement and the hold case. Long runs past both ends of the range show whether the counter saturates or wraps. The peak register is driven by a rise followed by a fall, then sampled with the lock high and low, which separates max tracking, snapshot reload and a blocked read. Full is checked one cycle below the threshold, at the threshold, and in both non-FIFO modes. Those points expose a compare that is off by one, a missing register stage, or a mode that is not gated.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

  typedef enum logic [1:0] {
    MODE_CIRC   = 2'd0,
    MODE_SWFIFO = 2'd1,
    MODE_HWFIFO = 2'd2,
    MODE_SPARE  = 2'd3
  } bufModeT;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;    // new capture session
    logic inc;    // net +1 word
    logic dec;    // net -1 word
    logic snap;   // peak read reload
    logic track;  // peak follows level
    logic cmpEn;  // watermark compare active
  } lvlStrobeT;

endpackage

// File: rtl/tfm_ctrl.sv
module tfm_ctrl
  import tfm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      captEn,
  input  logic [1:0] bufMode,
  input  logic      wordWr,
  input  logic      wordRd,
  input  logic      peakRdEn,
  input  logic      locked,
  output lvlStrobeT stb
);

  logic    enPrev;
  logic    edgeRise;
  bufModeT modeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= captEn;
  end

  assign edgeRise = captEn & ~enPrev;
  assign modeSel  = bufModeT'(bufMode);

  always_comb begin
    stb       = '0;
    stb.clr   = edgeRise;
    stb.inc   = captEn & ~edgeRise & wordWr & ~wordRd;
    stb.dec   = captEn & ~edgeRise & wordRd & ~wordWr;
    stb.snap  = peakRdEn & ~locked & ~edgeRise;
    stb.track = captEn & ~edgeRise;
    stb.cmpEn = captEn & ((modeSel == MODE_SWFIFO) || (modeSel == MODE_HWFIFO));
  end

  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.inc && stb.dec));                                   // R2
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> !stb.clr);                                    // R8
  AST_LOCK_NOSNAP: assert property (@(posedge clk) disable iff (!rstN)
    (locked && peakRdEn) |-> !stb.snap);                      // R6

endmodule

// File: rtl/tfm_datapath.sv
module tfm_datapath
  import tfm_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lvlStrobeT                stb,
  input  logic                     wmWrEn,
  input  logic [$clog2(DEPTH)-1:0] wmWrData,
  output logic [$clog2(DEPTH):0]   lvl,
  output logic [$clog2(DEPTH):0]   peak,
  output logic                     full
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

  logic [AW-1:0] wmReg;
  logic [LW-1:0] thresh;

  assign thresh = LVL_MAX - {1'b0, wmReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       wmReg <= '0;
    else if (wmWrEn) wmReg <= wmWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           lvl <= '0;
    else if (stb.clr)                    lvl <= '0;
    else if (stb.inc && lvl != LVL_MAX)  lvl <= lvl + LW'(1);
    else if (stb.dec && lvl != '0)       lvl <= lvl - LW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         peak <= '0;
    else if (stb.clr)                  peak <= '0;
    else if (stb.snap)                 peak <= lvl;
    else if (stb.track && lvl > peak)  peak <= lvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        full <= 1'b0;
    else if (stb.clr) full <= 1'b0;
    else              full <= stb.cmpEn && (lvl >= thresh);
  end

  AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    lvl <= LVL_MAX);                                          // R3
  AST_LVL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc && lvl != LVL_MAX && !stb.clr) |=> lvl == $past(lvl) + LW'(1)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (lvl == '0 && peak == '0));                   // R8
  AST_PEAK_KEEPS_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (stb.track && !stb.snap && !stb.clr) |=> peak >= $past(lvl)); // R4
  AST_FULL_OFF_NONFIFO: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cmpEn |=> !full);                                    // R10

endmodule

// File: rtl/trace_fill_mon.sv
module trace_fill_mon
  import tfm_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     captEn,
  input  logic [1:0]               bufMode,
  input  logic                     wordWr,
  input  logic                     wordRd,
  input  logic                     wmWrEn,
  input  logic [$clog2(DEPTH)-1:0] wmWrData,
  input  logic                     peakRdEn,
  input  logic                     locked,
  output logic [$clog2(DEPTH):0]   curLevel,
  output logic [$clog2(DEPTH):0]   peakLevel,
  output logic                     fullOut,
  output logic                     enClr
);

  localparam int LW = $clog2(DEPTH) + 1;

  lvlStrobeT     stb;
  logic [LW-1:0] lvl;
  logic [LW-1:0] peak;
  logic          full;

  tfm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .captEn   (captEn),
    .bufMode  (bufMode),
    .wordWr   (wordWr),
    .wordRd   (wordRd),
    .peakRdEn (peakRdEn),
    .locked   (locked),
    .stb      (stb)
  );

  tfm_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wmWrEn   (wmWrEn),
    .wmWrData (wmWrData),
    .lvl      (lvl),
    .peak     (peak),
    .full     (full)
  );

  assign curLevel  = captEn ? lvl : '0;
  assign peakLevel = locked ? '0 : peak;
  assign fullOut   = full;
  assign enClr     = stb.clr;

  AST_OFF_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !captEn |-> curLevel == '0);                              // R7
  AST_OFF_PEAK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!captEn && !peakRdEn) |=> $stable(peak));                // R7

endmodule

// File: tb/sim_trace_fill_mon.sv
`timescale 1ns/1ps
module sim_trace_fill_mon;

  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          captEn = 1'b0;
  logic [1:0]    bufMode = 2'd0;
  logic          wordWr = 1'b0;
  logic          wordRd = 1'b0;
  logic          wmWrEn = 1'b0;
  logic [AW-1:0] wmWrData = '0;
  logic          peakRdEn = 1'b0;
  logic          locked = 1'b0;
  logic [LW-1:0] curLevel;
  logic [LW-1:0] peakLevel;
  logic          fullOut;
  logic          enClr;

  int nChecks = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trace_fill_mon #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .captEn(captEn), .bufMode(bufMode),
    .wordWr(wordWr), .wordRd(wordRd), .wmWrEn(wmWrEn), .wmWrData(wmWrData),
    .peakRdEn(peakRdEn), .locked(locked), .curLevel(curLevel),
    .peakLevel(peakLevel), .fullOut(fullOut), .enClr(enClr)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs change at negedge; one edge passes
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pushWords(input int n);
    for (int i = 0; i < n; i++) begin
      wordWr = 1'b1; step();
    end
    wordWr = 1'b0;
  endtask

  task automatic popWords(input int n);
    for (int i = 0; i < n; i++) begin
      wordRd = 1'b1; step();
    end
    wordRd = 1'b0;
  endtask

  task automatic readPeak();
    peakRdEn = 1'b1; step(); peakRdEn = 1'b0;
  endtask

  task automatic startCapture();
    captEn = 1'b0; step();
    captEn = 1'b1; step();
  endtask

  task automatic t_reset();
    check("R1 level", curLevel, 0);
    check("R1 peak", peakLevel, 0);
    check("R1 full", fullOut, 0);
  endtask

  task automatic t_count();
    captEn = 1'b1;
    #1 check("R8 edge pulse", enClr, 1);
    wordWr = 1'b1;
    step();  // strobe ignored in edge cycle
    wordWr = 1'b0;
    check("R8 edge pulse ends", enClr, 0);
    check("R8 strobe ignored", curLevel, 0);
    pushWords(5);
    check("R2 write", curLevel, 5);
    wordWr = 1'b1; wordRd = 1'b1; step();
    wordWr = 1'b0; wordRd = 1'b0;
    check("R2 both hold", curLevel, 5);
    popWords(2);
    check("R2 read", curLevel, 3);
    check("R4 peak max", peakLevel, 5);
  endtask

  task automatic t_peak();
    readPeak();
    check("R5 reload", peakLevel, 3);
    pushWords(4); step();
    check("R4 rise", peakLevel, 7);
    popWords(4);
    locked = 1'b1;
    #1 check("R6 reads zero", peakLevel, 0);
    readPeak();
    locked = 1'b0;
    #1 check("R6 unchanged", peakLevel, 7);
    readPeak();
    check("R5 reload low", peakLevel, 3);
  endtask

  task automatic t_disable();
    captEn = 1'b0;
    #1 check("R7 level zero", curLevel, 0);
    step(); step();
    check("R7 peak kept", peakLevel, 3);
    captEn = 1'b1; step();
    check("R8 level cleared", curLevel, 0);
    check("R8 peak cleared", peakLevel, 0);
  endtask

  task automatic t_saturate();
    pushWords(DEPTH + 3);
    check("R3 top", curLevel, DEPTH);
    popWords(DEPTH + 2);
    check("R3 bottom", curLevel, 0);
  endtask

  task automatic t_full();
    wmWrData = AW'(4); wmWrEn = 1'b1; step(); wmWrEn = 1'b0;
    bufMode = 2'd1;
    pushWords(DEPTH - 5); step();
    check("R9 below", fullOut, 0);
    pushWords(1);
    check("R9 registered lag", fullOut, 0);
    step();
    check("R9 at threshold", fullOut, 1);
    popWords(1); step();
    check("R9 falls", fullOut, 0);
    bufMode = 2'd2; pushWords(1); step();
    check("R9 hw mode", fullOut, 1);
    bufMode = 2'd0; step(); step();
    check("R10 circular", fullOut, 0);
    bufMode = 2'd3; step(); step();
    check("R10 mode3", fullOut, 0);
  endtask

  task automatic t_maxwm();
    wmWrData = AW'(DEPTH - 1); wmWrEn = 1'b1; step(); wmWrEn = 1'b0;
    bufMode = 2'd1;
    startCapture();
    step();
    check("R11 empty", fullOut, 0);
    pushWords(1); step();
    check("R11 first word", fullOut, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_peak();
    t_disable();
    t_saturate();
    t_full();
    t_maxwm();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule